// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Controller

This block holds the wiper position registers of a small bank of digitally controlled potentiometer channels. It moves the register of one selected channel up or down by a single tap each time the serial bus clock rises. Once the command decoder has acknowledged a stepping command, it pulses `arm` and names the target channel. From then on the bus data line carries the step direction and the bus clock acts as the step clock. No byte framing and no acknowledges apply.

The block stays in stepping mode until the bus sees a stop or a new start condition. Upstream logic detects those conditions and passes them in as single-cycle flags. Rising edges of the bus clock come in the same way, together with the synchronised level of the data line. The counter never wraps: it stops at the all-ones tap going up and at zero going down. Stepping never touches persistent storage. A parallel load port lets other commands (direct writes, transfers, power-on recall) place a value in any channel's register.

Top module: `wiper_stepper`

## Requirements
- R1: After reset every wiper register reads 0, `active` is 0 and `step_pulse` is 0.
- R2: A cycle with `arm` high and no stop or start flag makes `active` read 1 from the next cycle and selects channel `arm_ch`. An `scl_rise` in the arming cycle itself moves nothing.
- R3: While `active` is 1, an `scl_rise` cycle with `sda_lvl` = 1 raises the selected channel's wiper by one. The new value is visible on `wiper_flat` one cycle later.
- R4: While `active` is 1, an `scl_rise` cycle with `sda_lvl` = 0 lowers the selected channel's wiper by one. The new value is visible one cycle later.
- R5: A step up from 2^W-1 leaves the value at 2^W-1, and a step down from 0 leaves it at 0. No register changes by more than one tap per cycle unless it is loaded.
- R6: A step changes only the selected channel. Channel `c` occupies bits `[c*W +: W]` of `wiper_flat`.
- R7: `stop_seen` clears `active` on the next cycle. An `scl_rise` in the same cycle as `stop_seen`, or at any point after it, moves no wiper.
- R8: `start_seen` also clears `active` on the next cycle, with the same effect on steps as R7.
- R9: While `active` is 0, `scl_rise` and `sda_lvl` have no effect on any wiper.
- R10: `ld_en` writes `ld_val` into channel `ld_ch` one cycle later. A load takes priority over a step that targets the same channel in the same cycle.
- R11: `step_pulse` is 1 for exactly one cycle, aligned with the new wiper value, after each step that changed a wiper. It stays 0 for a step that is blocked at an end stop or overridden by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | One-cycle flag: synchronised bus clock rose |
| sda_lvl | input | 1 | Synchronised bus data level (1 = up, 0 = down) |
| stop_seen | input | 1 | One-cycle flag: stop condition detected |
| start_seen | input | 1 | One-cycle flag: start condition detected |
| arm | input | 1 | One-cycle flag from decoder: stepping command acknowledged |
| arm_ch | input | CHW | Channel to step |
| ld_en | input | 1 | Parallel load strobe |
| ld_ch | input | CHW | Channel to load |
| ld_val | input | W | Value to load |
| active | output | 1 | Stepping mode is on |
| step_pulse | output | 1 | A wiper moved in the previous cycle |
| wiper_flat | output | NCH*W | All wiper registers, channel 0 in the low bits |

## Verification
The bench builds the block with two channels and a 4-bit wiper, so each end stop is only 15 steps away. Full sweeps past both limits, in both directions and on each channel, therefore stay short. Each step is compared against an arithmetic model of a clamped counter. The two-channel setting also brings within reach the isolation of the unselected channel and the cases where two things happen in one cycle: a step with a stop, a step with a load, and a step in the arming cycle.

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int NCH = 2,
  parameter int W   = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             sda_lvl,
  input  logic             stop_seen,
  input  logic             start_seen,
  input  logic             arm,
  input  logic [CHW-1:0]   arm_ch,
  input  logic             ld_en,
  input  logic [CHW-1:0]   ld_ch,
  input  logic [W-1:0]     ld_val,
  output logic             active,
  output logic             step_pulse,
  output logic [NCH*W-1:0] wiper_flat
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0]   wip [NCH];
  logic [CHW-1:0] sel;
  logic [W-1:0]   cur;

  wire leave  = stop_seen | start_seen;
  wire take   = active & scl_rise & ~leave;
  wire at_end = sda_lvl ? (cur == TOP) : (cur == '0);
  wire [W-1:0] nxt = sda_lvl ? cur + 1'b1 : cur - 1'b1;
  wire ld_hit = ld_en & (ld_ch == sel);

  always_comb begin
    cur = '0;
    for (int i = 0; i < NCH; i++)
      if (sel == CHW'(i)) cur = wip[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sel        <= '0;
      step_pulse <= 1'b0;
    end else begin
      if (leave) active <= 1'b0;
      else if (arm) begin
        active <= 1'b1;
        sel    <= arm_ch;
      end
      step_pulse <= take & ~at_end & ~ld_hit;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CHW-1:0] ID = CHW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wip[g] <= '0;
      else if (ld_en && ld_ch == ID)       wip[g] <= ld_val;
      else if (take && sel == ID && !at_end) wip[g] <= nxt;
    end
    assign wiper_flat[g*W +: W] = wip[g];
  end
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int NCH = 2,
  parameter int W   = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_rise,
  input logic             stop_seen,
  input logic             start_seen,
  input logic             arm,
  input logic             ld_en,
  input logic             active,
  input logic             step_pulse,
  input logic [NCH*W-1:0] wiper_flat
);
  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !active);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !active);

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !stop_seen && !start_seen |=> active);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !ld_en |=> $stable(wiper_flat));

  // R11
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $past(active) && $past(scl_rise) && !$past(stop_seen) && !$past(start_seen));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> ({1'b0, wiper_flat[g*W +: W]} == {1'b0, $past(wiper_flat[g*W +: W])}) ||
                 ({1'b0, wiper_flat[g*W +: W]} == {1'b0, $past(wiper_flat[g*W +: W])} + 1'b1) ||
                 ({1'b0, $past(wiper_flat[g*W +: W])} == {1'b0, wiper_flat[g*W +: W]} + 1'b1));
  end
endmodule

bind wiper_stepper wiper_stepper_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .stop_seen(stop_seen),
  .start_seen(start_seen), .arm(arm), .ld_en(ld_en), .active(active),
  .step_pulse(step_pulse), .wiper_flat(wiper_flat)
);

// File: tb/wiper_stepper_test.sv
module wiper_stepper_test;
  localparam int NCH = 2;
  localparam int W   = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic scl_rise = 0, sda_lvl = 0, stop_seen = 0, start_seen = 0;
  logic arm = 0, ld_en = 0;
  logic [0:0] arm_ch = 0, ld_ch = 0;
  logic [W-1:0] ld_val = 0;
  logic active, step_pulse;
  logic [NCH*W-1:0] wiper_flat;

  int tests = 0, fails = 0;
  int m_w [NCH];
  bit m_act = 0;
  int m_sel = 0;

  always #2 clk = ~clk;

  wiper_stepper #(.NCH(NCH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .sda_lvl(sda_lvl),
    .stop_seen(stop_seen), .start_seen(start_seen), .arm(arm), .arm_ch(arm_ch),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_val(ld_val), .active(active),
    .step_pulse(step_pulse), .wiper_flat(wiper_flat)
  );

  function automatic int wv(int ch);
    return int'(wiper_flat[ch*W +: W]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int pulse_exp);
    for (int c = 0; c < NCH; c++) check(req, wv(c), m_w[c]);
    check("R11 step_pulse", int'(step_pulse), pulse_exp);
    check({req, " active"}, int'(active), int'(m_act));
  endtask

  function automatic bit model_step(bit up);
    int b;
    if (!m_act) return 0;
    b = m_w[m_sel];
    if (up && b < MAXV) m_w[m_sel] = b + 1;
    else if (!up && b > 0) m_w[m_sel] = b - 1;
    return m_w[m_sel] != b;
  endfunction

  task automatic do_step(input bit up, input string req);
    bit mv;
    @(negedge clk); scl_rise = 1; sda_lvl = up;
    @(negedge clk); scl_rise = 0;
    mv = model_step(up);
    check_all(req, int'(mv));
  endtask

  task automatic do_arm(input int ch);
    @(negedge clk); arm = 1; arm_ch = 1'(ch);
    @(negedge clk); arm = 0;
    m_act = 1; m_sel = ch;
    check_all("R2 arm", 0);
  endtask

  task automatic do_stop(input bit use_start);
    @(negedge clk); if (use_start) start_seen = 1; else stop_seen = 1;
    @(negedge clk); start_seen = 0; stop_seen = 0;
    m_act = 0;
    check_all(use_start ? "R8 start exit" : "R7 stop exit", 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_w[c] = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) do_step(i[0], "R9 idle step");

    for (int ch = 0; ch < NCH; ch++) begin
      do_arm(ch);
      for (int i = 0; i < MAXV + 3; i++) do_step(1, "R3 R5 R6 up sweep");
      for (int i = 0; i < MAXV + 3; i++) do_step(0, "R4 R5 R6 down sweep");
      for (int i = 0; i < 12; i++) do_step((i % 3) != 0, "R3 R4 mixed");
      do_stop(ch == 1);
      do_step(1, "R7 R8 after exit");
    end

    do_arm(0);
    @(negedge clk); scl_rise = 1; sda_lvl = 1; stop_seen = 1;
    @(negedge clk); scl_rise = 0; stop_seen = 0;
    m_act = 0;
    check_all("R7 stop with step", 0);

    @(negedge clk); arm = 1; arm_ch = 1; scl_rise = 1; sda_lvl = 1;
    @(negedge clk); arm = 0; scl_rise = 0;
    m_act = 1; m_sel = 1;
    check_all("R2 arm cycle step", 0);
    do_step(1, "R3 after arm");

    @(negedge clk); ld_en = 1; ld_ch = 1; ld_val = 4'd9; scl_rise = 1; sda_lvl = 1;
    @(negedge clk); ld_en = 0; scl_rise = 0;
    m_w[1] = 9;
    check_all("R10 load beats step", 0);

    @(negedge clk); ld_en = 1; ld_ch = 0; ld_val = 4'(MAXV); scl_rise = 1; sda_lvl = 0;
    @(negedge clk); ld_en = 0; scl_rise = 0;
    m_w[0] = MAXV; void'(model_step(0));
    check_all("R10 load other channel", 1);

    do_arm(0);
    do_step(1, "R5 saturate after load");
    do_step(0, "R4 from top");
    do_stop(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule